// File: doc/BRIEF.md
# Addressing-Mode Instruction Fetch Sequencer

This block is the control sequencer at the front of a small 8-bit processor. It reads an opcode byte from a byte-wide memory port and classifies it by the two most significant opcode bits, which select the addressing mode. Depending on that mode, it reads zero, one or two more bytes. It assembles the register selectors and a 16-bit operand, which holds either an immediate value or an address. It then raises a single-clock execute strobe that carries everything the datapath needs.

All work is paced by a machine cycle of five clock periods. The opcode and each operand byte take one machine cycle. Periods 1 and 2 read memory at the program counter. Period 3 advances the program counter and decodes. Periods 4 and 5 are idle unless the instruction finishes, in which case period 4 of the last machine cycle carries the execute strobe. A taken-jump input, presented together with the strobe, redirects the program counter to the assembled operand before the next opcode read.

Top module: `opseq_fetch`

## Requirements
- R1: While `rst_n` is low, the program counter is 0000h and the sequencer is in period 1: `mem_addr` is 0000h, `mem_rd` is 1 and `exec_stb` is 0.
- R2: Every machine cycle lasts five clocks. `mem_rd` is 1 in periods 1 and 2 only, `mem_addr` is held for both of those periods, and the byte is taken from `mem_data` at the end of period 2.
- R3: The program counter (seen on `mem_addr`) increases by one at the end of period 3 of every machine cycle.
- R4: Opcode bits 7:6 select the mode and the number of machine cycles. 01 is inherent (1 cycle, no operand). 00 is immediate with one byte (2 cycles). 10 is immediate with two bytes (3 cycles). 11 is direct with a two-byte address (3 cycles).
- R5: `exec_stb` is 1 for exactly one clock, in period 4 of the last machine cycle of an instruction. It rises 5*N-2 clocks after period 1 of the opcode cycle, where N is the number of cycles from R4, and `mem_rd` is 0 while it is high.
- R6: `exec_operand` holds the first operand byte in bits 7:0 and the second in bits 15:8, so bytes ADh then DEh give DEADh. A one-byte immediate is zero-extended, and inherent mode gives 0000h.
- R7: During the strobe, `exec_opcode` is the opcode byte, `exec_mode` is its bits 7:6, `exec_src` is its bits 5:3 and `exec_dst` is its bits 2:0.
- R8: When `jump_taken` is 1 together with `exec_stb`, the next opcode is read from `exec_operand`. Otherwise the next opcode is read from the byte after the instruction. `jump_taken` has no effect in any clock without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_data | input | 8 | Byte returned by memory for `mem_addr` |
| jump_taken | input | 1 | Redirect request, sampled with `exec_stb` |
| mem_addr | output | 16 | Memory read address (program counter) |
| mem_rd | output | 1 | Memory read request |
| exec_stb | output | 1 | One-clock execute strobe |
| exec_opcode | output | 8 | Opcode of the instruction being executed |
| exec_mode | output | 2 | Addressing mode field |
| exec_src | output | 3 | Source register selector |
| exec_dst | output | 3 | Destination register selector |
| exec_operand | output | 16 | Assembled immediate value or address |

## Verification
A directed prologue places one instruction of each of the four modes in sequence. It includes the ADh, DEh operand pair, so each mode's cycle count and byte order can be told apart from the others. A long random byte stream follows. It mixes all modes with random register fields and random operand values, which separates correct lane placement and zero-extension from swapped or stale bytes. During that stream, `jump_taken` is driven randomly on every clock. Jumps therefore land at arbitrary addresses, and stray requests outside the strobe show whether the redirect is gated to the strobe alone.

// File: rtl/opseq_pkg.sv
// Package: shared types and timing constants of the fetch sequencer.
// Assumes one machine cycle per fetched byte.
package opseq_pkg;

    typedef enum logic [1:0] {
        MODE_IMM8  = 2'b00,
        MODE_INH   = 2'b01,
        MODE_IMM16 = 2'b10,
        MODE_DIR   = 2'b11
    } addr_mode_e;

    localparam int unsigned PERIODS   = 5;  // clocks per machine cycle
    localparam int unsigned PER_LATCH = 1;  // zero-based period that captures the byte
    localparam int unsigned PER_INC   = 2;  // zero-based period that advances the PC
    localparam int unsigned PER_EXEC  = 3;  // zero-based period of the execute strobe

endpackage

// File: rtl/opseq_period_ctr.sv
// Module: counts the clock periods of one machine cycle, 0 .. PERIODS-1.
// Assumes PERIODS >= 2. wrap_o flags the final period.
module opseq_period_ctr #(
    parameter int unsigned PERIODS = 5,
    localparam int unsigned PW = $clog2(PERIODS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o,
    output logic          wrap_o
);
    localparam logic [PW-1:0] LAST = PW'(PERIODS - 1);

    assign wrap_o = (phase_o == LAST);

    // Advance the period index, returning to zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_o <= '0;
        else if (wrap_o) phase_o <= '0;
        else             phase_o <= phase_o + 1'b1;
    end
endmodule

// File: rtl/opseq_mode_dec.sv
// Module: decodes an opcode into mode, machine-cycle count and register fields.
// Assumes the mode sits in the top two opcode bits. Purely combinational.
module opseq_mode_dec
    import opseq_pkg::*;
(
    input  logic [7:0]  opcode_i,
    output addr_mode_e  mode_o,
    output logic [1:0]  ncyc_o,
    output logic [2:0]  src_o,
    output logic [2:0]  dst_o
);
    assign mode_o = addr_mode_e'(opcode_i[7:6]);
    assign src_o  = opcode_i[5:3];
    assign dst_o  = opcode_i[2:0];

    // Number of machine cycles: the opcode cycle plus one per operand byte.
    always_comb begin
        case (mode_o)
            MODE_INH:   ncyc_o = 2'd1;
            MODE_IMM8:  ncyc_o = 2'd2;
            default:    ncyc_o = 2'd3;
        endcase
    end
endmodule

// File: rtl/opseq_operand_asm.sv
// Module: assembles the multi-byte operand one lane at a time.
// Assumes lane 0 arrives first (least significant). clr_i zeroes all lanes.
module opseq_operand_asm #(
    parameter int unsigned DW     = 8,
    parameter int unsigned NBYTES = 2,
    localparam int unsigned LW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 ld_i,
    input  logic [LW-1:0]        lane_i,
    input  logic [DW-1:0]        data_i,
    output logic [DW*NBYTES-1:0] operand_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [DW-1:0] lane_q;

        // Hold one operand byte; zeroed at each new opcode.
        always_ff @(posedge clk) begin
            if (!rst_n)                          lane_q <= '0;
            else if (clr_i)                      lane_q <= '0;
            else if (ld_i && lane_i == LW'(g))   lane_q <= data_i;
        end

        assign operand_o[g*DW +: DW] = lane_q;
    end
endmodule

// File: rtl/opseq_fetch.sv
// Module: top of the fetch sequencer. It holds the program counter, the
// instruction register and the step index, and issues the execute strobe.
// Assumes memory returns mem_data for mem_addr within the two read periods.
module opseq_fetch
    import opseq_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_data,
    input  logic          jump_taken,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          exec_stb,
    output logic [DW-1:0] exec_opcode,
    output logic [1:0]    exec_mode,
    output logic [2:0]    exec_src,
    output logic [2:0]    exec_dst,
    output logic [AW-1:0] exec_operand
);
    localparam int unsigned PW     = $clog2(PERIODS);
    localparam int unsigned NBYTES = AW / DW;
    localparam int unsigned LW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PW-1:0] P_LATCH = PW'(PER_LATCH);
    localparam logic [PW-1:0] P_INC   = PW'(PER_INC);
    localparam logic [PW-1:0] P_EXEC  = PW'(PER_EXEC);

    logic [PW-1:0] phase_q;
    logic          wrap;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] ir_q;
    logic [1:0]    step_q;
    addr_mode_e    mode;
    logic [1:0]    ncyc;
    logic          last_step;
    logic          latch_en;
    logic [1:0]    lane_full;

    opseq_period_ctr #(.PERIODS(PERIODS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase_q),
        .wrap_o  (wrap)
    );

    opseq_mode_dec u_dec (
        .opcode_i (ir_q),
        .mode_o   (mode),
        .ncyc_o   (ncyc),
        .src_o    (exec_src),
        .dst_o    (exec_dst)
    );

    assign latch_en  = (phase_q == P_LATCH);
    assign last_step = ((step_q + 2'd1) == ncyc);
    assign lane_full = step_q - 2'd1;

    opseq_operand_asm #(.DW(DW), .NBYTES(NBYTES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (latch_en && step_q == 2'd0),
        .ld_i      (latch_en && step_q != 2'd0),
        .lane_i    (LW'(lane_full)),
        .data_i    (mem_data),
        .operand_o (exec_operand)
    );

    // Capture the opcode at the end of the read in the first machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ir_q <= '0;
        else if (latch_en && step_q == 2'd0) ir_q <= mem_data;
    end

    // Step through the machine cycles of one instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= 2'd0;
        else if (wrap) step_q <= last_step ? 2'd0 : step_q + 2'd1;
    end

    // Program counter: jump on a taken strobe, otherwise advance in period 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pc_q <= '0;
        else if (exec_stb && jump_taken) pc_q <= exec_operand;
        else if (phase_q == P_INC)      pc_q <= pc_q + 1'b1;
    end

    assign mem_addr    = pc_q;
    assign mem_rd      = (phase_q <= P_LATCH);
    assign exec_stb    = (phase_q == P_EXEC) && last_step;
    assign exec_opcode = ir_q;
    assign exec_mode   = mode;
endmodule

// File: rtl/opseq_fetch_chk.sv
// Module: property checker for opseq_fetch, bound to every instance.
// Assumes the period index is brought in through the bind.
module opseq_fetch_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          exec_stb,
    input logic          jump_taken,
    input logic [AW-1:0] exec_operand,
    input logic [PW-1:0] phase_q
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb);                                   // R5
    AST_STB_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> !mem_rd);                                     // R5
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PW'(2)) |=> mem_addr == $past(mem_addr) + 1'b1); // R3
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && jump_taken) |=> mem_addr == $past(exec_operand)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));          // R2
endmodule

bind opseq_fetch opseq_fetch_chk #(.AW(AW), .PW($clog2(opseq_pkg::PERIODS))) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .exec_stb     (exec_stb),
    .jump_taken   (jump_taken),
    .exec_operand (exec_operand),
    .phase_q      (phase_q)
);

// File: tb/opseq_fetch_tb_top.sv
// Bench: directed mode prologue, then a random byte stream with random jumps.
module opseq_fetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NINSTR     = 300;
    localparam int MEMSZ      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_taken = 1'b0;
    logic [7:0]  mem_data;
    logic [15:0] mem_addr;
    logic        mem_rd, exec_stb;
    logic [7:0]  exec_opcode;
    logic [1:0]  exec_mode;
    logic [2:0]  exec_src, exec_dst;
    logic [15:0] exec_operand;

    logic [7:0] mem [MEMSZ];
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_data = mem[mem_addr[9:0]];

    opseq_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .jump_taken(jump_taken),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .exec_stb(exec_stb),
        .exec_opcode(exec_opcode), .exec_mode(exec_mode), .exec_src(exec_src),
        .exec_dst(exec_dst), .exec_operand(exec_operand)
    );

    function automatic int cycles_of(input logic [7:0] op);
        case (op[7:6])
            2'b01:   return 1;
            2'b00:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [15:0] operand_of(input logic [15:0] pc);
        logic [7:0] op;
        op = mem[pc[9:0]];
        case (cycles_of(op))
            1:       return 16'h0000;
            2:       return {8'h00, mem[10'(pc + 16'd1)]};
            default: return {mem[10'(pc + 16'd2)], mem[10'(pc + 16'd1)]};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] pc, nxt, opd;
        logic [7:0]  op;
        int n, gap;
        bit got;
        void'($urandom(32'h5EED));
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
        // Directed prologue: inherent, imm8, imm16 (DEADh), direct.
        mem[0] = 8'h47;
        mem[1] = 8'h3F; mem[2] = 8'h5A;
        mem[3] = 8'h80; mem[4] = 8'hAD; mem[5] = 8'hDE;
        mem[6] = 8'hC1; mem[7] = 8'h34; mem[8] = 8'h12;

        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(mem_addr == 16'h0000, "R1 addr", 32'(mem_addr), 0);
        chk(mem_rd == 1'b1,       "R1 rd",   32'(mem_rd), 1);
        chk(exec_stb == 1'b0,     "R1 stb",  32'(exec_stb), 0);
        rst_n = 1'b1;

        pc = 16'h0000;
        for (int k = 0; k < NINSTR; k++) begin
            op  = mem[pc[9:0]];
            n   = cycles_of(op);
            opd = operand_of(pc);
            gap = 0;
            got = 0;
            while (!got && gap < 30) begin
                @(negedge clk);
                gap++;
                jump_taken = (k < 4) ? 1'b0 : ($urandom % 3 == 0);
                if (exec_stb) got = 1;
            end
            chk(gap == 5*n - 2, "R4/R5 strobe timing", 32'(gap), 32'(5*n - 2));
            chk(exec_opcode == op, "R7 opcode", 32'(exec_opcode), 32'(op));
            chk(exec_mode == op[7:6] && exec_src == op[5:3] && exec_dst == op[2:0],
                "R7 fields", {24'h0, exec_mode, exec_src, exec_dst}, {24'h0, op});
            chk(exec_operand == opd, "R6 operand", 32'(exec_operand), 32'(opd));
            chk(!mem_rd, "R5 no read during strobe", 32'(mem_rd), 0);
            chk(mem_addr == pc + 16'(n), "R3 pc advance", 32'(mem_addr), 32'(pc + 16'(n)));
            nxt = jump_taken ? opd : pc + 16'(n);
            @(negedge clk);
            jump_taken = 1'($urandom);
            chk(!exec_stb && !mem_rd, "R5 single strobe / R2 idle",
                {30'h0, exec_stb, mem_rd}, 0);
            @(negedge clk);
            jump_taken = 1'($urandom);
            chk(mem_rd && mem_addr == nxt, "R8 next fetch / R2 read",
                32'(mem_addr), 32'(nxt));
            pc = nxt;
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule